// File: doc/BRIEF.md
# Vectored Message-Signalled Interrupt Generator

This block sits between a function's interrupt sources and its outbound write path. A source raises a request strobe with a vector number. The block checks the request against the current configuration. It then either formats an address/data message for the memory-write path or holds the vector as pending. Configuration comes from an external capability register file as levels:

- the enable bit;
- the encoded vector count;
- the address mode;
- whether per-vector masking exists;
- the two address words;
- the 16-bit data word;
- the per-vector mask bits.

A strobe marks each configuration write into the capability.

Messages leave one at a time on a valid/ready handshake. Vectors that cannot be sent at once are kept in two internal bitmaps and are delivered later, lowest vector first:

- **Masked-pending:** vectors whose mask bit was set when they were requested. This bitmap is visible on `pend_o` for the register file.
- **Stall queue:** vectors that arrived while the output was busy. This bitmap is internal.

A control state machine has three states:

- `ST_OFF`: delivery is disabled.
- `ST_IDLE`: enabled, with no message presented.
- `ST_SEND`: a message is presented and waits for `msg_ready`.

It has these transitions:

- `OFF->IDLE` when the enable bit is set.
- `IDLE->OFF` when the enable bit clears.
- `IDLE->SEND` (launch) when enabled and at least one vector is deliverable.
- `SEND->IDLE` when the message is accepted.

Top module: `msi_msg_gen`

## Requirements
- R1: While `msi_en` is 0, a request strobe changes neither the bitmaps nor the output, and no message is launched; a request dropped this way is not delivered after a later enable.
- R2: A request whose vector is at or above the enabled count N is dropped: no message and no pending bit.
- R3: N is 2 to the power of `vec_log2`. A `vec_log2` value larger than log2(MAX_VEC) is treated as log2(MAX_VEC).
- R4: `msg_data[31:16]` is zero. `msg_data[15:0]` is `data_cfg`, with its low log2(N) bits replaced by the vector number. With N=1 it is `data_cfg` unchanged.
- R5: With `addr64_mode`=1, `msg_addr` is {`addr_hi`, `addr_lo`}. Otherwise it is `addr_lo` zero-extended. In both modes, address bits 1:0 are forced to zero.
- R6: With `mask_cap`=1 and `mask_bits[v]`=1, a legal request for vector v sets `pend_o[v]` and emits no message.
- R7: With `mask_cap`=0, the mask bits are ignored, every legal request is delivered, and `pend_o` stays zero.
- R8: When `mask_bits[v]` clears while `pend_o[v]` is set, the vector's message is emitted and `pend_o[v]` clears.
- R9: A `cfg_wr` pulse while `msi_en`=1 discards pending bits at or above the current N.
- R10: When several vectors are deliverable, messages go out in ascending vector order.
- R11: Only one message is presented at a time. `msg_valid`, `msg_addr` and `msg_data` hold until a cycle with `msg_ready`=1.
- R12: A request that arrives while a message is stalled is kept and delivered later, so none is lost.
- R13: After reset, `msg_valid` is 0 and `pend_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Interrupt request strobe |
| req_vec | input | $clog2(MAX_VEC) | Requested vector number |
| msi_en | input | 1 | Message delivery enabled |
| vec_log2 | input | 3 | log2 of enabled vector count |
| addr64_mode | input | 1 | Use the 64-bit address |
| mask_cap | input | 1 | Per-vector masking present |
| cfg_wr | input | 1 | Pulse: configuration write into the capability |
| addr_lo | input | 32 | Message address, low word |
| addr_hi | input | 32 | Message address, high word |
| data_cfg | input | 16 | Message data template |
| mask_bits | input | MAX_VEC | Per-vector mask bits |
| pend_o | output | MAX_VEC | Masked-pending bits |
| msg_valid | output | 1 | Message presented |
| msg_ready | input | 1 | Message accepted |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The bench targets these cases:

- **Stalled output with a burst of later requests.** If the design dropped queued requests, messages would go missing. If it ignored priority, they would come out of ascending order.
- **Shrinking N with a configuration write.** This checks that a stale high vector is discarded rather than delivered later.
- **Illegal vectors and requests made while disabled.** A design that filtered these loosely would leave a pending bit or send a spurious message.
- **Data merge at N=1 and at a clamped count.** Off-by-one mask widths here would corrupt the low bits of the data template.

// File: rtl/msi_gen_pkg.sv
package msi_gen_pkg;
    localparam int ADDR_HALF_W = 32;
    localparam int MSG_ADDR_W  = 2 * ADDR_HALF_W;
    localparam int MSG_DATA_W  = 32;
    localparam int CFG_DATA_W  = 16;
    localparam int LOG_W       = 3;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_IDLE,
        ST_SEND
    } gen_state_e;
endpackage

// File: rtl/msi_vec_window.sv
// Clamps the encoded vector count and builds the legal-vector window.
module msi_vec_window
    import msi_gen_pkg::*;
#(
    parameter int MAX_VEC = 32
) (
    input  logic [LOG_W-1:0]   vec_log2,
    output logic [LOG_W-1:0]   eff_log2,
    output logic [MAX_VEC-1:0] win
);
    localparam int MAX_LOG = $clog2(MAX_VEC);

    always_comb begin
        if (vec_log2 > LOG_W'(MAX_LOG)) eff_log2 = LOG_W'(MAX_LOG);
        else                            eff_log2 = vec_log2;
    end

    for (genvar i = 0; i < MAX_VEC; i++) begin : g_win
        assign win[i] = (32'(i) < (32'd1 << eff_log2));
    end
endmodule

// File: rtl/msi_low_pick.sv
// Lowest-index set bit finder.
module msi_low_pick #(
    parameter int WIDTH = 32,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] cand,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (cand[i]) idx = IDX_W'(i);
        end
        any = |cand;
    end
endmodule

// File: rtl/msi_msg_fmt.sv
// Forms the message address and data for one vector.
module msi_msg_fmt
    import msi_gen_pkg::*;
#(
    parameter int MAX_VEC = 32,
    localparam int IDX_W = $clog2(MAX_VEC)
) (
    input  logic [IDX_W-1:0]       vec,
    input  logic [LOG_W-1:0]       eff_log2,
    input  logic                   addr64_mode,
    input  logic [ADDR_HALF_W-1:0] addr_lo,
    input  logic [ADDR_HALF_W-1:0] addr_hi,
    input  logic [CFG_DATA_W-1:0]  data_cfg,
    output logic [MSG_ADDR_W-1:0]  addr_n,
    output logic [MSG_DATA_W-1:0]  data_n
);
    logic [CFG_DATA_W-1:0] low_mask;
    logic [CFG_DATA_W-1:0] merged;
    logic [ADDR_HALF_W-1:0] lo_aligned;

    always_comb begin
        low_mask   = (CFG_DATA_W'(1) << eff_log2) - CFG_DATA_W'(1);
        merged     = (data_cfg & ~low_mask) | (CFG_DATA_W'(vec) & low_mask);
        data_n     = {{(MSG_DATA_W - CFG_DATA_W){1'b0}}, merged};
        lo_aligned = {addr_lo[ADDR_HALF_W-1:2], 2'b00};
        addr_n     = addr64_mode ? {addr_hi, lo_aligned}
                                 : {{ADDR_HALF_W{1'b0}}, lo_aligned};
    end
endmodule

// File: rtl/msi_pend_track.sv
// Masked-pending and stall-queue bitmaps plus deliverable set.
module msi_pend_track #(
    parameter int MAX_VEC = 32,
    localparam int IDX_W = $clog2(MAX_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [IDX_W-1:0]   req_vec,
    input  logic               msi_en,
    input  logic               mask_cap,
    input  logic [MAX_VEC-1:0] mask_bits,
    input  logic               cfg_wr,
    input  logic [MAX_VEC-1:0] win,
    input  logic               launch,
    input  logic [IDX_W-1:0]   launch_vec,
    output logic [MAX_VEC-1:0] pend_o,
    output logic [MAX_VEC-1:0] cand
);
    logic [MAX_VEC-1:0] pend_q, wait_q;
    logic [MAX_VEC-1:0] req_oh, clr_oh, trim, mask_eff;
    logic               req_ok, req_masked;

    always_comb begin
        req_oh     = MAX_VEC'(1) << req_vec;
        clr_oh     = launch ? (MAX_VEC'(1) << launch_vec) : '0;
        req_ok     = req_valid && msi_en && win[req_vec];
        mask_eff   = mask_cap ? mask_bits : '0;
        req_masked = req_ok && mask_eff[req_vec];
        trim       = (cfg_wr && msi_en) ? win : '1;
        cand       = (wait_q | (pend_q & ~mask_eff)) & win;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            wait_q <= '0;
        end else begin
            pend_q <= ((pend_q & ~clr_oh) | (req_masked ? req_oh : '0)) & trim;
            wait_q <= ((wait_q & ~clr_oh)
                       | ((req_ok && !req_masked) ? req_oh : '0)) & trim;
        end
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/msi_msg_gen.sv
// Top: control FSM and output message register.
module msi_msg_gen
    import msi_gen_pkg::*;
#(
    parameter int MAX_VEC = 32,
    localparam int IDX_W = $clog2(MAX_VEC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [IDX_W-1:0]       req_vec,
    input  logic                   msi_en,
    input  logic [LOG_W-1:0]       vec_log2,
    input  logic                   addr64_mode,
    input  logic                   mask_cap,
    input  logic                   cfg_wr,
    input  logic [ADDR_HALF_W-1:0] addr_lo,
    input  logic [ADDR_HALF_W-1:0] addr_hi,
    input  logic [CFG_DATA_W-1:0]  data_cfg,
    input  logic [MAX_VEC-1:0]     mask_bits,
    output logic [MAX_VEC-1:0]     pend_o,
    output logic                   msg_valid,
    input  logic                   msg_ready,
    output logic [MSG_ADDR_W-1:0]  msg_addr,
    output logic [MSG_DATA_W-1:0]  msg_data
);
    gen_state_e state_q, state_n;

    logic [LOG_W-1:0]      eff_log2;
    logic [MAX_VEC-1:0]    win, cand;
    logic                  cand_any, launch;
    logic [IDX_W-1:0]      pick_vec;
    logic [MSG_ADDR_W-1:0] addr_n;
    logic [MSG_DATA_W-1:0] data_n;

    msi_vec_window #(.MAX_VEC(MAX_VEC)) u_win (
        .vec_log2 (vec_log2),
        .eff_log2 (eff_log2),
        .win      (win)
    );

    msi_pend_track #(.MAX_VEC(MAX_VEC)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_vec    (req_vec),
        .msi_en     (msi_en),
        .mask_cap   (mask_cap),
        .mask_bits  (mask_bits),
        .cfg_wr     (cfg_wr),
        .win        (win),
        .launch     (launch),
        .launch_vec (pick_vec),
        .pend_o     (pend_o),
        .cand       (cand)
    );

    msi_low_pick #(.WIDTH(MAX_VEC)) u_pick (
        .cand (cand),
        .any  (cand_any),
        .idx  (pick_vec)
    );

    msi_msg_fmt #(.MAX_VEC(MAX_VEC)) u_fmt (
        .vec         (pick_vec),
        .eff_log2    (eff_log2),
        .addr64_mode (addr64_mode),
        .addr_lo     (addr_lo),
        .addr_hi     (addr_hi),
        .data_cfg    (data_cfg),
        .addr_n      (addr_n),
        .data_n      (data_n)
    );

    // Next-state logic
    always_comb begin
        state_n = state_q;
        launch  = 1'b0;
        unique case (state_q)
            ST_OFF:  if (msi_en) state_n = ST_IDLE;
            ST_IDLE: begin
                if (!msi_en) begin
                    state_n = ST_OFF;
                end else if (cand_any) begin
                    state_n = ST_SEND;
                    launch  = 1'b1;
                end
            end
            ST_SEND: if (msg_ready) state_n = ST_IDLE;
            default: state_n = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_n;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_addr <= '0;
            msg_data <= '0;
        end else if (launch) begin
            msg_addr <= addr_n;
            msg_data <= data_n;
        end
    end

    assign msg_valid = (state_q == ST_SEND);
endmodule

// File: rtl/msi_msg_gen_chk.sv
module msi_msg_gen_chk #(
    parameter int MAX_VEC = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               msi_en,
    input logic               mask_cap,
    input logic [MAX_VEC-1:0] pend_o,
    input logic               msg_valid,
    input logic               msg_ready,
    input logic [63:0]        msg_addr,
    input logic [31:0]        msg_data
);
    // R11
    msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=>
            (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    // R4
    data_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_data[31:16] == 16'h0));

    // R1
    launch_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> $past(msi_en));

    // R6
    pend_rise_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend_o & ~$past(pend_o))) |-> $past(req_valid && mask_cap && msi_en));

    // R7
    no_cap_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(mask_cap) && ($past(pend_o) == '0)) |-> (pend_o == '0));
endmodule

bind msi_msg_gen msi_msg_gen_chk #(.MAX_VEC(MAX_VEC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .msi_en    (msi_en),
    .mask_cap  (mask_cap),
    .pend_o    (pend_o),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data)
);

// File: tb/msi_msg_gen_tb_top.sv
module msi_msg_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_VEC    = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_vec = '0;
    logic        msi_en = 1'b0;
    logic [2:0]  vec_log2 = '0;
    logic        addr64_mode = 1'b0;
    logic        mask_cap = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [31:0] addr_lo = 32'h8000_0007;
    logic [31:0] addr_hi = 32'hDEAD_BEEF;
    logic [15:0] data_cfg = 16'h1230;
    logic [31:0] mask_bits = '0;
    logic [31:0] pend_o;
    logic        msg_valid;
    logic        msg_ready = 1'b0;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    msi_msg_gen #(.MAX_VEC(MAX_VEC)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vec(req_vec),
        .msi_en(msi_en), .vec_log2(vec_log2), .addr64_mode(addr64_mode),
        .mask_cap(mask_cap), .cfg_wr(cfg_wr), .addr_lo(addr_lo),
        .addr_hi(addr_hi), .data_cfg(data_cfg), .mask_bits(mask_bits),
        .pend_o(pend_o), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic setup(input bit en, input logic [2:0] lg, input bit a64,
                         input bit cap, input logic [31:0] msk);
        msi_en = en; vec_log2 = lg; addr64_mode = a64;
        mask_cap = cap; mask_bits = msk;
        @(negedge clk);
    endtask

    task automatic pulse_req(input logic [4:0] v);
        req_valid = 1'b1; req_vec = v;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic pulse_cfg();
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic take_msg(input logic [63:0] ea, input logic [31:0] ed,
                            input string tag);
        int n = 0;
        while (!msg_valid && n < 20) begin
            @(negedge clk);
            n++;
        end
        if (!msg_valid) begin
            check(1'b0, {tag, " message missing"}, 64'(msg_valid), 64'd1);
        end else begin
            check(msg_addr == ea, {tag, " addr"}, msg_addr, ea);
            check(msg_data == ed, {tag, " data"}, 64'(msg_data), 64'(ed));
            msg_ready = 1'b1;
            @(negedge clk);
            msg_ready = 1'b0;
        end
    endtask

    task automatic expect_quiet(input string tag);
        bit seen = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (msg_valid) seen = 1'b1;
            @(negedge clk);
        end
        check(!seen, {tag, " unexpected message"}, 64'(seen), 64'd0);
    endtask

    localparam logic [63:0] A32 = 64'h0000_0000_8000_0004;
    localparam logic [63:0] A64 = 64'hDEAD_BEEF_8000_0004;

    task automatic t_reset();
        check(msg_valid == 1'b0, "R13 valid after reset", 64'(msg_valid), 64'd0);
        check(pend_o == '0, "R13 pend after reset", 64'(pend_o), 64'd0);
    endtask

    task automatic t_basic();
        setup(1, 3'd3, 0, 1, '0);
        pulse_req(5'd5);
        take_msg(A32, 32'h0000_1235, "R4 R5 vec5 N=8 32-bit");
        addr64_mode = 1'b1; data_cfg = 16'hABCF;
        pulse_req(5'd2);
        take_msg(A64, 32'h0000_ABCA, "R4 R5 vec2 64-bit");
        addr64_mode = 1'b0; vec_log2 = 3'd0; data_cfg = 16'h5A5F;
        pulse_req(5'd0);
        take_msg(A32, 32'h0000_5A5F, "R4 N=1 data unchanged");
        data_cfg = 16'h1230;
    endtask

    task automatic t_clamp();
        setup(1, 3'd7, 0, 1, '0);
        data_cfg = 16'hAB40;
        pulse_req(5'd31);
        take_msg(A32, 32'h0000_AB5F, "R3 clamp vec31");
        pulse_req(5'd16);
        take_msg(A32, 32'h0000_AB50, "R3 clamp vec16");
        data_cfg = 16'h1230;
    endtask

    task automatic t_illegal();
        setup(1, 3'd2, 0, 1, '1);
        pulse_req(5'd4);
        check(pend_o == '0, "R2 illegal masked no pend", 64'(pend_o), 64'd0);
        mask_bits = '0;
        expect_quiet("R2 illegal vec4 N=4");
    endtask

    task automatic t_disabled();
        setup(0, 3'd3, 0, 1, '0);
        pulse_req(5'd1);
        check(pend_o == '0, "R1 disabled no pend", 64'(pend_o), 64'd0);
        msi_en = 1'b1;
        expect_quiet("R1 disabled request dropped");
    endtask

    task automatic t_mask();
        setup(1, 3'd3, 0, 1, 32'h0000_0010);
        pulse_req(5'd4);
        check(pend_o == 32'h10, "R6 masked sets pend", 64'(pend_o), 64'h10);
        expect_quiet("R6 masked no message");
        mask_bits = '0;
        take_msg(A32, 32'h0000_1234, "R8 unmask delivers");
        check(pend_o == '0, "R8 pend cleared", 64'(pend_o), 64'd0);
    endtask

    task automatic t_nocap();
        setup(1, 3'd3, 0, 0, '1);
        pulse_req(5'd3);
        check(pend_o == '0, "R7 no cap no pend", 64'(pend_o), 64'd0);
        take_msg(A32, 32'h0000_1233, "R7 mask ignored");
    endtask

    task automatic t_order();
        setup(1, 3'd3, 0, 1, 32'h0000_0028);
        pulse_req(5'd5);
        pulse_req(5'd3);
        check(pend_o == 32'h28, "R10 two pending", 64'(pend_o), 64'h28);
        mask_bits = '0;
        take_msg(A32, 32'h0000_1233, "R10 first vec3");
        take_msg(A32, 32'h0000_1235, "R10 then vec5");
        check(pend_o == '0, "R10 pend drained", 64'(pend_o), 64'd0);
    endtask

    task automatic t_discard();
        setup(1, 3'd3, 0, 1, 32'h0000_0042);
        pulse_req(5'd6);
        pulse_req(5'd1);
        check(pend_o == 32'h42, "R9 before trim", 64'(pend_o), 64'h42);
        vec_log2 = 3'd1;
        pulse_cfg();
        check(pend_o == 32'h02, "R9 high pend discarded", 64'(pend_o), 64'h02);
        mask_bits = '0;
        take_msg(A32, 32'h0000_1231, "R9 vec1 delivered N=2");
        expect_quiet("R9 vec6 not delivered");
    endtask

    task automatic t_stall();
        setup(1, 3'd3, 0, 1, '0);
        pulse_req(5'd2);
        pulse_req(5'd4);
        pulse_req(5'd1);
        check(msg_valid == 1'b1, "R11 held while stalled", 64'(msg_valid), 64'd1);
        check(msg_data == 32'h1232, "R11 stalled data stable", 64'(msg_data), 64'h1232);
        take_msg(A32, 32'h0000_1232, "R12 first vec2");
        take_msg(A32, 32'h0000_1231, "R12 queued vec1");
        take_msg(A32, 32'h0000_1234, "R12 queued vec4");
        expect_quiet("R12 no extra");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_clamp();
        t_illegal();
        t_disabled();
        t_mask();
        t_nocap();
        t_order();
        t_discard();
        t_stall();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule